// File: doc/BRIEF.md
# Multi-Source External Interrupt Detector

This block turns a set of external pin events into a single interrupt request for a processor core. One dedicated interrupt pin, active low, is always a source. A group of general port pins, active high, can join it as extra sources when the port-interrupt enable is set. All sources are merged into one active-high combined signal. A rising edge of that combined signal is caught in one shared pending latch.

A detection-mode input selects the request behaviour. In edge-only mode the request comes from the pending latch alone. In edge-plus-level mode the request also stays high while the combined signal is active. The core clears the pending latch with an acknowledge pulse. An interrupt mask gates the request output, but the latch keeps recording edges while the mask is set.

A separate status output shows the raw level of the dedicated pin only. Software can test that pin without seeing the merged request. The port pin inputs are expected to be synchronized already.

Top module: `irq_merge_top`

## Requirements
- R1: After reset, with the dedicated pin high and all port pins low, `irqReq` is 0 in both modes, and no pending edge is left over.
- R2: In edge-only mode (`levelMode`=0), with the mask clear, a falling level on `irqPinN` raises `irqReq` at the first clock edge after the change. `irqReq` then stays high after the pin returns high, until an acknowledge.
- R3: A port pin in `portPins` is a source only while `portIrqEn`=1. With `portIrqEn`=0, a port pin going high leaves `irqReq` at 0, including after later clock edges.
- R4: Port pins are active high, so only a rising port level sets the pending latch. A port pin falling from 1 to 0 does not raise `irqReq`.
- R5: An `intAck` pulse for one cycle, with no new edge in that cycle, clears the pending latch. In edge-only mode, `irqReq` drops at that clock edge even if the combined signal is still active.
- R6: If a new rising edge of the combined signal arrives in the same cycle as `intAck`, the pending latch stays set and `irqReq` stays 1.
- R7: In edge-plus-level mode (`levelMode`=1), `irqReq` is high in the same cycle that the combined signal is active. It stays high after an acknowledge for as long as the combined signal stays active. Once the signal goes inactive, after the acknowledge, `irqReq` falls.
- R8: While `intMask`=1, `irqReq` is 0. An edge that arrives while masked is still latched, so `irqReq` rises as soon as the mask is cleared.
- R9: `irqPinStat` equals `irqPinN` at all times. It is not affected by the port pins or by the pending latch.
- R10: All sources share one latch. A second source becoming active while the combined signal is already active is not a new edge, so after an acknowledge `irqReq` stays 0 in edge-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| portPins | input | NUM_PORT_SRC | Synchronized port pin levels, active high |
| irqPinN | input | 1 | Dedicated interrupt pin, active low |
| portIrqEn | input | 1 | 1 = port pins act as interrupt sources |
| levelMode | input | 1 | 0 = edge only, 1 = edge plus level |
| intMask | input | 1 | 1 = request output masked |
| intAck | input | 1 | Acknowledge pulse, clears the pending latch |
| irqReq | output | 1 | Interrupt request to the core |
| irqPinStat | output | 1 | Raw level of the dedicated pin |

## Verification
The bench builds the block with the default of four port sources, so every port pin can be driven on its own. With four sources, the bench can also make two port pins overlap, and can overlap a port pin with the dedicated pin. This exercises the shared-latch rule: a second source joining an already-active combined signal must not count as a new edge. With all four pins present, the enable gating can also be checked on a pin other than bit zero.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  // Strobes that the control issues to the datapath latch.
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } pendStrobe_t;

  // Request-generation style selected by the mode input.
  typedef enum logic {
    DET_EDGE       = 1'b0,
    DET_EDGE_LEVEL = 1'b1
  } detectMode_e;

endpackage

// File: rtl/irq_merge_datapath.sv
module irq_merge_datapath
  import irq_merge_pkg::*;
#(
  parameter int NUM_PORT_SRC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PORT_SRC-1:0] portPins,
  input  logic                    irqPinN,
  input  logic                    portIrqEn,
  input  pendStrobe_t             strobe,
  output logic                    combActive,
  output logic                    edgeDet,
  output logic                    pendingQ,
  output logic                    irqPinStat
);

  localparam int LastSrc = NUM_PORT_SRC - 1;

  logic [LastSrc:0] gatedPort;
  logic             anyPort;
  logic             prevActive;

  // Per-pin enable gating of the port sources.
  for (genvar i = 0; i < NUM_PORT_SRC; i++) begin : g_gate
    assign gatedPort[i] = portPins[i] & portIrqEn;
  end

  assign anyPort    = |gatedPort;
  assign combActive = ~irqPinN | anyPort;
  assign edgeDet    = combActive & ~prevActive;
  assign irqPinStat = irqPinN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevActive <= 1'b0;
    end else begin
      prevActive <= combActive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingQ <= 1'b0;
    end else if (strobe.setPend) begin
      pendingQ <= 1'b1;
    end else if (strobe.clrPend) begin
      pendingQ <= 1'b0;
    end
  end

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    edgeDet |=> pendingQ); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clrPend && !strobe.setPend) |=> !pendingQ); // R5

  AST_PORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!portIrqEn && irqPinN) |-> !combActive); // R3

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pendingQ && !strobe.setPend) |=> !pendingQ); // R10

endmodule

// File: rtl/irq_merge_control.sv
module irq_merge_control
  import irq_merge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        levelMode,
  input  logic        intMask,
  input  logic        intAck,
  input  logic        combActive,
  input  logic        edgeDet,
  input  logic        pendingQ,
  output pendStrobe_t strobe,
  output logic        irqReq
);

  detectMode_e mode;
  logic        levelTerm;
  logic        rawReq;

  assign mode = detectMode_e'(levelMode);

  // A fresh edge wins over an acknowledge in the same cycle.
  always_comb begin
    strobe         = '0;
    strobe.setPend = edgeDet;
    strobe.clrPend = intAck & ~edgeDet;
  end

  always_comb begin
    unique case (mode)
      DET_EDGE_LEVEL: levelTerm = combActive;
      default:        levelTerm = 1'b0;
    endcase
  end

  assign rawReq = pendingQ | levelTerm;
  assign irqReq = rawReq & ~intMask;

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    intMask |-> !irqReq); // R8

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (levelMode && !intMask && combActive) |-> irqReq); // R7

  AST_EDGE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!levelMode && !pendingQ) |-> !irqReq); // R5

endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top
  import irq_merge_pkg::*;
#(
  parameter int NUM_PORT_SRC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PORT_SRC-1:0] portPins,
  input  logic                    irqPinN,
  input  logic                    portIrqEn,
  input  logic                    levelMode,
  input  logic                    intMask,
  input  logic                    intAck,
  output logic                    irqReq,
  output logic                    irqPinStat
);

  pendStrobe_t strobe;
  logic        combActive;
  logic        edgeDet;
  logic        pendingQ;

  irq_merge_datapath #(.NUM_PORT_SRC(NUM_PORT_SRC)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .portPins   (portPins),
    .irqPinN    (irqPinN),
    .portIrqEn  (portIrqEn),
    .strobe     (strobe),
    .combActive (combActive),
    .edgeDet    (edgeDet),
    .pendingQ   (pendingQ),
    .irqPinStat (irqPinStat)
  );

  irq_merge_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .levelMode  (levelMode),
    .intMask    (intMask),
    .intAck     (intAck),
    .combActive (combActive),
    .edgeDet    (edgeDet),
    .pendingQ   (pendingQ),
    .strobe     (strobe),
    .irqReq     (irqReq)
  );

  AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (irqPinN && !$past(irqPinN)) |-> irqPinStat); // R9

endmodule

// File: tb/irq_merge_top_test.sv
`timescale 1ns/1ps
module irq_merge_top_test;

  localparam int NSRC = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] portPins = '0;
  logic            irqPinN = 1'b1;
  logic            portIrqEn = 1'b0;
  logic            levelMode = 1'b0;
  logic            intMask = 1'b0;
  logic            intAck = 1'b0;
  logic            irqReq;
  logic            irqPinStat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_merge_top #(.NUM_PORT_SRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .portPins(portPins), .irqPinN(irqPinN),
    .portIrqEn(portIrqEn), .levelMode(levelMode), .intMask(intMask),
    .intAck(intAck), .irqReq(irqReq), .irqPinStat(irqPinStat)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Return pins to idle and flush any pending edge.
  task automatic settle();
    irqPinN = 1'b1; portPins = '0; intMask = 1'b0; tick();
    intAck = 1'b1; tick();
    intAck = 1'b0; tick();
  endtask

  task automatic ackPulse();
    intAck = 1'b1; tick();
    intAck = 1'b0;
  endtask

  task automatic t_reset();
    check(irqReq, 1'b0, "R1 edge mode after reset");
    levelMode = 1'b1; #1;
    check(irqReq, 1'b0, "R1 level mode after reset");
    levelMode = 1'b0; tick();
  endtask

  task automatic t_irqPin();
    irqPinN = 1'b0; #1;
    check(irqReq, 1'b0, "R2 not before clock");
    tick();
    check(irqReq, 1'b1, "R2 latched after clock");
    irqPinN = 1'b1; tick();
    check(irqReq, 1'b1, "R2 held after pin release");
    ackPulse(); #1;
    check(irqReq, 1'b0, "R5 cleared by ack");
    settle();
  endtask

  task automatic t_portEnable();
    portIrqEn = 1'b0; portPins[2] = 1'b1; tick(); tick();
    check(irqReq, 1'b0, "R3 disabled port ignored");
    portPins = '0; tick();
    portIrqEn = 1'b1; portPins[3] = 1'b1; tick();
    check(irqReq, 1'b1, "R3 enabled port rising");
    ackPulse(); #1;
    check(irqReq, 1'b0, "R5 ack while still active, edge mode");
    portPins[3] = 1'b0; tick(); tick();
    check(irqReq, 1'b0, "R4 falling port level ignored");
    settle();
  endtask

  task automatic t_ackCollision();
    irqPinN = 1'b0; tick();
    irqPinN = 1'b1; tick();
    // new edge and ack in the same cycle
    portPins[1] = 1'b1; intAck = 1'b1; tick();
    intAck = 1'b0; #1;
    check(irqReq, 1'b1, "R6 edge beats ack");
    settle();
  endtask

  task automatic t_level();
    levelMode = 1'b1;
    irqPinN = 1'b0; #1;
    check(irqReq, 1'b1, "R7 level same cycle");
    tick(); ackPulse(); #1;
    check(irqReq, 1'b1, "R7 held after ack while active");
    irqPinN = 1'b1; #1;
    check(irqReq, 1'b0, "R7 falls when inactive");
    levelMode = 1'b0;
    settle();
  endtask

  task automatic t_mask();
    intMask = 1'b1; portPins[0] = 1'b1; tick();
    check(irqReq, 1'b0, "R8 masked");
    portPins[0] = 1'b0; tick();
    check(irqReq, 1'b0, "R8 still masked");
    intMask = 1'b0; #1;
    check(irqReq, 1'b1, "R8 latched edge shows on unmask");
    settle();
  endtask

  task automatic t_status();
    portPins = '1; tick();
    check(irqPinStat, 1'b1, "R9 port pins not seen on status");
    irqPinN = 1'b0; #1;
    check(irqPinStat, 1'b0, "R9 follows dedicated pin");
    settle();
  endtask

  task automatic t_shared();
    portPins[0] = 1'b1; tick();
    check(irqReq, 1'b1, "R10 first source");
    ackPulse();
    portPins[2] = 1'b1; tick();
    irqPinN = 1'b0; tick();
    check(irqReq, 1'b0, "R10 overlapping sources no new edge");
    settle();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_irqPin();
    t_portEnable();
    t_ackCollision();
    t_level();
    t_mask();
    t_status();
    t_shared();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule